// File: doc/BRIEF.md
# Test Pattern Receive Checker

This block watches a received serial bit stream, one bit per valid cycle, and compares it with one of two expected patterns. In static mode the expected pattern is a 16-bit word that repeats and is sent most significant bit first. In pseudo-random mode it is a PRBS-7 stream. The checker first acquires lock on the incoming stream without being given its phase, and raises a sync flag once it has lock. From then on it compares every valid bit with its own prediction and counts each mismatch in a saturating error counter.

When the checker sees a dense burst of errors it drops lock and acquires again. Deasserting the receive enable discards all acquisition state. The error count holds until the enable is raised again, and that rising edge clears it. A link test harness reads the sync flag and the 32-bit error count word to judge the quality of a serial link.

Top module: `pattern_rx_checker`

## Requirements
- R1: `mode_prbs`=1 selects PRBS-7, where bit b[n] = b[n-6] XOR b[n-7] (polynomial x^7+x^6+1). `mode_prbs`=0 selects the static mode, where `static_word` repeats and its bit 15 is sent first.
- R2: In PRBS mode, once 7 valid bits have arrived, each later bit is predicted from the previous 7 received bits. `sync_o` rises in the cycle after the 32nd consecutive correct prediction. On a clean stream from enable, that is the cycle after the 39th valid bit.
- R3: In static mode, `sync_o` rises in the cycle after a valid bit that completes 32 received bits in which both 16-bit halves are equal and match a rotation of `static_word`. On a clean stream, that is the cycle after the 32nd valid bit.
- R4: Mismatches are counted only while locked. Each mismatched valid bit adds one to `err_cnt_o`, visible in the next cycle. Mismatches during acquisition leave the count unchanged.
- R5: While locked, if the current mismatch brings the error total over the last 64 locked valid bits to 8, that mismatch is counted and `sync_o` falls in the next cycle. Acquisition then restarts from zero.
- R6: The counter saturates at all ones of its CNT_W bits (0xFFFFFF by default) and holds there. `err_cnt_o` is 32 bits wide with the bits above CNT_W zero.
- R7: The count is cleared only by a 0-to-1 transition of `rx_en`, visible in the next cycle. At all other times it never decreases, including while `rx_en` is low.
- R8: While `rx_en` is low, `sync_o` is low in the same cycle and data is ignored. Any lock or partial acquisition is discarded, so after re-enabling a full acquisition is needed.
- R9: Cycles with `bit_vld` low do not advance acquisition, prediction or counting, whatever `bit_in` holds.
- R10: After reset, `sync_o` is 0 and `err_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; rising edge clears the count |
| mode_prbs | input | 1 | 1 = PRBS-7, 0 = static word |
| static_word | input | WORD_W | Expected static word, MSB sent first |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | Qualifies `bit_in` |
| sync_o | output | 1 | Lock flag |
| err_cnt_o | output | STAT_W | Saturating error count, zero-extended |

## Verification
Two things can fall on the same clock: counting a mismatch and losing lock, because the eighth error in a 64-bit window is both counted and drops sync. The bench provokes this with a burst of eight flipped bits after a clean stretch. It checks that sync is still high after the seventh error and low after the eighth, and that the count rose by exactly eight. In the saturation run and the random soak, mismatches also arrive while the counter is at its ceiling. Each cycle is judged against a bench model built from the requirements.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic {MODE_STATIC = 1'b0, MODE_PRBS = 1'b1} prc_mode_e;

  // PRBS-7 next bit from a history whose bit 0 is the newest bit
  function automatic logic prbs7_pred(input logic [15:0] h);
    return h[6] ^ h[5];
  endfunction
endpackage

// File: rtl/prc_bit_history.sv
module prc_bit_history #(
  parameter int HIST_W = 32,
  localparam int FILL_W = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              step,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_q,
  output logic [FILL_W-1:0] fill_q
);
  logic [HIST_W-1:0] hist_d;
  logic [FILL_W-1:0] fill_d;

  always_comb begin
    hist_d = hist_q;
    fill_d = fill_q;
    if (!en) begin
      hist_d = '0;
      fill_d = '0;
    end else if (step) begin
      hist_d = {hist_q[HIST_W-2:0], bit_in};
      if (fill_q != FILL_W'(HIST_W)) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  // R9
  hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> ($stable(hist_q) && $stable(fill_q)));
endmodule

// File: rtl/prc_lock_tracker.sv
module prc_lock_tracker
  import prc_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LOCK_RUN  = 32,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 8,
  localparam int HIST_W = 2 * WORD_W,
  localparam int FILL_W = $clog2(HIST_W + 1),
  localparam int RUN_W  = $clog2(LOCK_RUN + 1),
  localparam int WCNT_W = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              step,
  input  prc_mode_e         mode,
  input  logic [WORD_W-1:0] word,
  input  logic              bit_in,
  input  logic [HIST_W-1:0] hist_q,
  input  logic [FILL_W-1:0] fill_q,
  output logic              locked_q,
  output logic              err_hit
);
  logic              locked_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [WORD_W-1:0] exp_q, exp_d;
  logic [WIN-1:0]    flags_q, flags_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [HIST_W-1:0] hist_n;
  logic [WORD_W-1:0] rot_hit;
  logic              static_ok, pred;
  logic [2*WORD_W-1:0] dbl_word;

  assign hist_n   = {hist_q[HIST_W-2:0], bit_in};
  assign dbl_word = {word, word};

  // one comparator per alignment of the static word
  for (genvar k = 0; k < WORD_W; k++) begin : g_rot
    assign rot_hit[k] = (hist_n[WORD_W-1:0] == dbl_word[2*WORD_W-1-k -: WORD_W]);
  end

  assign static_ok = (fill_q >= FILL_W'(HIST_W - 1)) &&
                     (hist_n[HIST_W-1:WORD_W] == hist_n[WORD_W-1:0]) && (|rot_hit);

  always_comb begin
    locked_d = locked_q;
    run_d    = run_q;
    exp_d    = exp_q;
    flags_d  = flags_q;
    wcnt_d   = wcnt_q;
    err_hit  = 1'b0;
    pred     = 1'b0;
    if (!en) begin
      locked_d = 1'b0;
      run_d    = '0;
      flags_d  = '0;
      wcnt_d   = '0;
    end else if (step) begin
      if (locked_q) begin
        pred    = (mode == MODE_PRBS) ? prbs7_pred(16'(exp_q)) : exp_q[WORD_W-1];
        err_hit = bit_in ^ pred;
        exp_d   = {exp_q[WORD_W-2:0], pred};
        flags_d = {flags_q[WIN-2:0], err_hit};
        wcnt_d  = wcnt_q + WCNT_W'(err_hit) - WCNT_W'(flags_q[WIN-1]);
        if (wcnt_d >= WCNT_W'(ERR_LIMIT)) begin
          locked_d = 1'b0;
          run_d    = '0;
          flags_d  = '0;
          wcnt_d   = '0;
        end
      end else if (mode == MODE_PRBS) begin
        if (fill_q >= FILL_W'(7)) begin
          run_d = (prbs7_pred(16'(hist_q)) == bit_in) ? run_q + 1'b1 : '0;
        end
        if (run_d == RUN_W'(LOCK_RUN)) begin
          locked_d = 1'b1;
          run_d    = '0;
          exp_d    = hist_n[WORD_W-1:0];
        end
      end else if (static_ok) begin
        locked_d = 1'b1;
        exp_d    = hist_n[WORD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      run_q    <= '0;
      exp_q    <= '0;
      flags_q  <= '0;
      wcnt_q   <= '0;
    end else begin
      locked_q <= locked_d;
      run_q    <= run_d;
      exp_q    <= exp_d;
      flags_q  <= flags_d;
      wcnt_q   <= wcnt_d;
    end
  end

  // R2 R3
  lock_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(step));
  // R5
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> (wcnt_q < WCNT_W'(ERR_LIMIT)));
  // R8
  drop_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked_q);
  // R9
  no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> ($stable(locked_q) && $stable(exp_q) && $stable(run_q)));
endmodule

// File: rtl/prc_err_counter.sv
module prc_err_counter #(
  parameter int CNT_W  = 24,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [STAT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = STAT_W'(cnt_q);

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));
  // R7
  no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q >= $past(cnt_q)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/pattern_rx_checker.sv
module pattern_rx_checker
  import prc_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LOCK_RUN  = 32,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 8,
  parameter int CNT_W     = 24,
  parameter int STAT_W    = 32,
  localparam int HIST_W = 2 * WORD_W,
  localparam int FILL_W = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              mode_prbs,
  input  logic [WORD_W-1:0] static_word,
  input  logic              bit_in,
  input  logic              bit_vld,
  output logic              sync_o,
  output logic [STAT_W-1:0] err_cnt_o
);
  logic              en_q, en_rise, step, locked, err_hit;
  logic [HIST_W-1:0] hist;
  logic [FILL_W-1:0] fill;
  prc_mode_e         mode;

  assign mode    = prc_mode_e'(mode_prbs);
  assign step    = rx_en & bit_vld;
  assign en_rise = rx_en & ~en_q;
  assign sync_o  = locked & rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= rx_en;
  end

  prc_bit_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .step(step), .bit_in(bit_in),
    .hist_q(hist), .fill_q(fill)
  );

  prc_lock_tracker #(.WORD_W(WORD_W), .LOCK_RUN(LOCK_RUN), .WIN(WIN),
                     .ERR_LIMIT(ERR_LIMIT)) u_lock (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .step(step), .mode(mode),
    .word(static_word), .bit_in(bit_in), .hist_q(hist), .fill_q(fill),
    .locked_q(locked), .err_hit(err_hit)
  );

  prc_err_counter #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(en_rise), .inc(err_hit), .cnt_o(err_cnt_o)
  );

  // R4
  count_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_o && !en_rise) |=> $stable(err_cnt_o));
  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt_o[STAT_W-1:CNT_W] == '0);
endmodule

// File: tb/pattern_rx_checker_test.sv
module pattern_rx_checker_test;
  localparam int CW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n, rx_en, mode_prbs, bit_in, bit_vld;
  logic [15:0] static_word;
  logic        sync_o;
  logic [31:0] err_cnt_o;

  int tests = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_hist;
  int          m_fill, m_run, m_wcnt, m_cnt;
  logic        m_locked, m_enq;
  logic [15:0] m_exp;
  logic [63:0] m_flags;
  logic [6:0]  tx_s;
  int          tx_i;

  pattern_rx_checker #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode_prbs(mode_prbs),
    .static_word(static_word), .bit_in(bit_in), .bit_vld(bit_vld),
    .sync_o(sync_o), .err_cnt_o(err_cnt_o)
  );

  always #10 clk = ~clk;

  function automatic bit rot_match(input logic [15:0] h, input logic [15:0] w);
    for (int k = 0; k < 16; k++)
      if (h == ((w << k) | (w >> (16 - k)))) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    m_hist = '0; m_fill = 0; m_run = 0; m_wcnt = 0; m_locked = 0;
    m_exp = '0; m_flags = '0;
  endtask

  task automatic model_step();
    logic [31:0] hn;
    logic pred, e;
    if (rx_en && !m_enq) m_cnt = 0;
    if (!rx_en) model_reset();
    else if (bit_vld) begin
      hn = {m_hist[30:0], bit_in};
      if (m_locked) begin
        pred = mode_prbs ? (m_exp[6] ^ m_exp[5]) : m_exp[15];
        e = bit_in ^ pred;
        m_exp = {m_exp[14:0], pred};
        m_wcnt = m_wcnt + int'(e) - int'(m_flags[63]);
        m_flags = {m_flags[62:0], e};
        if (e && m_cnt < MAXC) m_cnt++;
        if (m_wcnt >= 8) begin
          m_locked = 0; m_run = 0; m_flags = '0; m_wcnt = 0;
        end
      end else if (mode_prbs) begin
        if (m_fill >= 7) m_run = ((m_hist[6] ^ m_hist[5]) == bit_in) ? m_run + 1 : 0;
        if (m_run == 32) begin m_locked = 1; m_run = 0; m_exp = hn[15:0]; end
      end else if (m_fill >= 31 && hn[31:16] == hn[15:0] && rot_match(hn[15:0], static_word)) begin
        m_locked = 1; m_exp = hn[15:0];
      end
      m_hist = hn;
      if (m_fill < 32) m_fill++;
    end
    m_enq = rx_en;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic e, input logic v, input logic b, input string tag);
    rx_en = e; bit_vld = v; bit_in = b;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(sync_o === (m_locked & rx_en), {tag, " sync"}, int'(sync_o), int'(m_locked & rx_en));
    check(err_cnt_o === 32'(m_cnt), {tag, " count"}, int'(err_cnt_o), m_cnt);
  endtask

  function automatic logic tx_next();
    logic b;
    if (mode_prbs) begin
      b = tx_s[6] ^ tx_s[5];
      tx_s = {tx_s[5:0], b};
    end else begin
      b = static_word[15 - tx_i];
      tx_i = (tx_i + 1) % 16;
    end
    return b;
  endfunction

  // n valid bits with random invalid gaps (R9); flip one bit every err_every (0 = never)
  task automatic send(input int n, input int err_every, input string tag);
    for (int i = 1; i <= n; i++) begin
      if ($urandom_range(3) == 0) cyc(1'b1, 1'b0, 1'($urandom), {tag, " gap R9"});
      cyc(1'b1, 1'b1, tx_next() ^ (err_every != 0 && i % err_every == 0), tag);
    end
  endtask

  task automatic disable_for(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'($urandom), 1'($urandom), "R8 disabled");
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; rx_en = 0; mode_prbs = 1; bit_in = 0; bit_vld = 0;
    static_word = 16'hC3A5; tx_s = 7'h5A; tx_i = 0;
    model_reset(); m_cnt = 0; m_enq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    check(sync_o === 1'b0, "R10 reset sync", int'(sync_o), 0);
    check(err_cnt_o === 32'd0, "R10 reset count", int'(err_cnt_o), 0);

    // R2 R1: PRBS lock after 39 clean valid bits
    send(38, 0, "R2 acquire");
    check(sync_o === 1'b0, "R2 not yet locked", int'(sync_o), 0);
    send(1, 0, "R2 acquire");
    check(sync_o === 1'b1, "R2 locked at bit 39", int'(sync_o), 1);

    // R4: sparse errors while locked
    base = int'(err_cnt_o);
    send(200, 12, "R4 locked errors");
    check(int'(err_cnt_o) == base + 16, "R4 count of 16", int'(err_cnt_o), base + 16);

    // R5: flush window, then eight consecutive errors
    send(70, 0, "R5 flush");
    base = int'(err_cnt_o);
    send(7, 1, "R5 burst");
    check(sync_o === 1'b1, "R5 still locked at 7", int'(sync_o), 1);
    send(1, 1, "R5 burst");
    check(sync_o === 1'b0, "R5 lost at 8", int'(sync_o), 0);
    check(int'(err_cnt_o) == base + 8, "R5 eighth counted", int'(err_cnt_o), base + 8);

    // R4: errors during acquisition are not counted
    base = int'(err_cnt_o);
    send(30, 5, "R4 unlocked errors");
    check(int'(err_cnt_o) == base, "R4 no count unlocked", int'(err_cnt_o), base);
    send(40, 0, "R2 relock");
    check(sync_o === 1'b1, "R2 relocked", int'(sync_o), 1);

    // R8 R7: disabled -> sync low, count held; rise clears
    send(50, 7, "R4 more errors");
    base = int'(err_cnt_o);
    disable_for(40);
    check(int'(err_cnt_o) == base, "R7 held while off", int'(err_cnt_o), base);
    cyc(1'b1, 1'b0, 1'b0, "R7 enable rise");
    check(err_cnt_o === 32'd0, "R7 cleared on rise", int'(err_cnt_o), 0);
    send(38, 0, "R8 full reacquire");
    check(sync_o === 1'b0, "R8 no early lock", int'(sync_o), 0);

    // R3 R1: static mode, random word, lock after 32 valid bits
    disable_for(2);
    mode_prbs = 0; static_word = 16'($urandom); tx_i = $urandom_range(15);
    send(31, 0, "R3 acquire");
    check(sync_o === 1'b0, "R3 not yet locked", int'(sync_o), 0);
    send(1, 0, "R3 acquire");
    check(sync_o === 1'b1, "R3 locked at bit 32", int'(sync_o), 1);
    send(150, 11, "R1 static errors");
    check(int'(err_cnt_o) == 13, "R1 static count", int'(err_cnt_o), 13);

    // R6: saturation
    disable_for(2);
    mode_prbs = 1; tx_s = 7'h11;
    send(39, 0, "R6 lock");
    send(2700, 10, "R6 saturate");
    check(int'(err_cnt_o) == MAXC, "R6 at ceiling", int'(err_cnt_o), MAXC);
    check(err_cnt_o[31:CW] == '0, "R6 upper zero", int'(err_cnt_o[31:CW]), 0);

    // random soak against the model (R1..R9)
    for (int ep = 0; ep < 120; ep++) begin
      disable_for($urandom_range(1, 4));
      mode_prbs = 1'($urandom); static_word = 16'($urandom);
      tx_s = 7'($urandom_range(1, 127)); tx_i = $urandom_range(15);
      for (int i = 0; i < 160; i++) begin
        logic fl;
        fl = ($urandom_range(ep % 3 == 0 ? 6 : 40) == 0);
        if ($urandom_range(4) == 0) cyc(1'b1, 1'b0, 1'($urandom), "R9 soak gap");
        cyc(1'b1, 1'b1, tx_next() ^ fl, "R4 R5 soak");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule